// File: doc/BRIEF.md
# Twisted-Pair Transceiver Mode and Collision Controller

This block sits beside the analog front end of a twisted-pair Ethernet transceiver. It decides where the receive-side outputs get their values. They come either from the transmit side through an internal loopback or from the line receiver. It also drives the collision and jabber status outputs. Three active-low strap inputs choose the mode: a loop test, a post-frame signal-quality-error (SQE) self-test, and full duplex. A jabber flag from the transmit watchdog overrides the loopback and collision logic.

In normal half-duplex operation the transmit data is echoed to the receive outputs while link pulses are present. Overlapping transmit and line activity raises the collision output. In loop-test mode the transmit path always feeds the receive outputs, and line data is dropped. In full-duplex mode the line is always routed and collisions are never flagged. When the SQE test is enabled, the collision output gives a timed pulse after every transmitted frame. The delay and width of that pulse are parameters in clock cycles.

All outputs are registered once. Reset is synchronous and active low.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rx_en`, `rx_data`, `col_out` and `jab_out` are all 0 after that edge.
- R2: With `loop_n`=1, `fdx_n`=1 and `jabber`=0, and with `tx_en`=1 and `link_ok`=1, the next edge gives `rx_en`=1 and `rx_data` equal to the sampled `tx_data`.
- R3: In the same normal mode, when `tx_en`=0 or `link_ok`=0, the next edge gives `rx_en`=`line_act` and `rx_data`=`line_data`.
- R4: With `loop_n`=0 and `jabber`=0, `rx_en` follows `tx_en` and `rx_data` carries `tx_data` whatever the value of `link_ok`. When `tx_en`=0, `rx_en` and `rx_data` are 0 even if the line is active. `col_out` is not raised by line activity.
- R5: With `loop_n`=1, `fdx_n`=1 and `jabber`=0, `tx_en`=1 together with `line_act`=1 makes `col_out` 1 at the next edge, while `jab_out` stays 0.
- R6: With `fdx_n`=0, `loop_n`=1 and `jabber`=0, the line is always routed (`rx_en`=`line_act`, `rx_data`=`line_data`), and concurrent activity does not raise `col_out`.
- R7: With `sqe_en_n`=0, take E0 as the edge that samples `tx_en`=0 after it was 1. `col_out` is then 1 after edges E0+SQE_DLY+1 through E0+SQE_DLY+SQE_WIN, and 0 on either side of that span. `rx_en` and `rx_data` are unaffected.
- R8: With `sqe_en_n`=1, the end of a frame produces no pulse on `col_out`.
- R9: While `jabber`=1, both `col_out` and `jab_out` are 1 after the next edge. Loopback is disabled: `loop_n`=1 routes the line, and `loop_n`=0 forces the receive outputs to 0. A pending SQE pulse is cancelled.
- R10: The SQE pulse of R7 also occurs with `fdx_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable; its falling edge ends a frame |
| tx_data | input | DATA_W | Transmit data |
| line_act | input | 1 | Line receiver unsquelched |
| line_data | input | DATA_W | Data recovered from the line |
| link_ok | input | 1 | Link pulses being received |
| loop_n | input | 1 | Loop test mode, active low |
| sqe_en_n | input | 1 | SQE self-test enable, active low |
| fdx_n | input | 1 | Full duplex, active low |
| jabber | input | 1 | Jabber condition from the transmit watchdog |
| rx_en | output | 1 | Receive enable toward the MAC |
| rx_data | output | DATA_W | Receive data toward the MAC |
| col_out | output | 1 | Collision / SQE / jabber status |
| jab_out | output | 1 | Jabber status |

## Verification
Routing, collision and jabber results pass through a single output register, so each is due at the first clock edge after the inputs that cause it. The bench drives inputs on the falling edge and samples on the next falling edge, one rising edge later. The SQE pulse is timed from the edge that samples the frame's end. For the SQE tests, the bench walks cycle by cycle from that edge and compares `col_out` against a window computed from SQE_DLY and SQE_WIN. This covers the cycle just before the window opens and the cycle just after it closes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   // Source selected for the receive-side outputs
   typedef enum logic [1:0] {
      ROUTE_LINE = 2'd0,
      ROUTE_LOOP = 2'd1,
      ROUTE_MUTE = 2'd2
   } route_e;
endpackage

// File: rtl/xcvr_route_sel.sv
module xcvr_route_sel
   import xcvr_pkg::*;
(
   input  logic   loop_n,
   input  logic   fdx_n,
   input  logic   jabber,
   input  logic   tx_en,
   input  logic   link_ok,
   output route_e route
);
   always_comb begin
      if (jabber)
         route = loop_n ? ROUTE_LINE : ROUTE_MUTE;
      else if (!loop_n)
         route = tx_en ? ROUTE_LOOP : ROUTE_MUTE;
      else if (!fdx_n)
         route = ROUTE_LINE;
      else
         route = (tx_en && link_ok) ? ROUTE_LOOP : ROUTE_LINE;
   end
endmodule

// File: rtl/xcvr_col_det.sv
module xcvr_col_det (
   input  logic loop_n,
   input  logic fdx_n,
   input  logic jabber,
   input  logic tx_en,
   input  logic line_act,
   output logic col_now
);
   // Only half-duplex normal operation can report a true collision
   logic half_normal;
   assign half_normal = loop_n && fdx_n && !jabber;
   assign col_now     = half_normal && tx_en && line_act;
endmodule

// File: rtl/xcvr_sqe_timer.sv
module xcvr_sqe_timer #(
   parameter int SQE_DLY = 2,
   parameter int SQE_WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic test_en,
   input  logic kill,
   output logic sqe_on
);
   localparam int TOTAL = SQE_DLY + SQE_WIN;
   localparam int CNT_W = (TOTAL < 2) ? 1 : $clog2(TOTAL + 1);
   localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TOTAL);
   localparam logic [CNT_W-1:0] WIN_V  = CNT_W'(SQE_WIN);

   logic             tx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             frame_end;

   assign frame_end = tx_q && !tx_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         tx_q <= tx_en;
         if (kill)
            cnt_q <= '0;
         else if (frame_end && test_en)
            cnt_q <= LOAD_V;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign sqe_on = (cnt_q != '0) && (cnt_q <= WIN_V);
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
   import xcvr_pkg::*;
#(
   parameter int DATA_W  = 1,
   parameter int SQE_DLY = 2,
   parameter int SQE_WIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              line_act,
   input  logic [DATA_W-1:0] line_data,
   input  logic              link_ok,
   input  logic              loop_n,
   input  logic              sqe_en_n,
   input  logic              fdx_n,
   input  logic              jabber,
   output logic              rx_en,
   output logic [DATA_W-1:0] rx_data,
   output logic              col_out,
   output logic              jab_out
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SQE_DLY < 0 || SQE_WIN < 0 || SQE_DLY + SQE_WIN > 65535) begin : g_bad_sqe
         $error("SQE timing parameters out of range");
      end
   endgenerate

   route_e route;
   logic   col_now;
   logic   sqe_on;

   xcvr_route_sel u_route (
      .loop_n (loop_n),
      .fdx_n  (fdx_n),
      .jabber (jabber),
      .tx_en  (tx_en),
      .link_ok(link_ok),
      .route  (route)
   );

   xcvr_col_det u_col (
      .loop_n  (loop_n),
      .fdx_n   (fdx_n),
      .jabber  (jabber),
      .tx_en   (tx_en),
      .line_act(line_act),
      .col_now (col_now)
   );

   generate
      if (SQE_WIN > 0) begin : g_sqe
         xcvr_sqe_timer #(.SQE_DLY(SQE_DLY), .SQE_WIN(SQE_WIN)) u_sqe (
            .clk    (clk),
            .rst_n  (rst_n),
            .tx_en  (tx_en),
            .test_en(!sqe_en_n),
            .kill   (jabber),
            .sqe_on (sqe_on)
         );
      end else begin : g_no_sqe
         assign sqe_on = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en   <= 1'b0;
         rx_data <= '0;
         col_out <= 1'b0;
         jab_out <= 1'b0;
      end else begin
         unique case (route)
            ROUTE_LOOP: begin
               rx_en   <= tx_en;
               rx_data <= tx_data;
            end
            ROUTE_MUTE: begin
               rx_en   <= 1'b0;
               rx_data <= '0;
            end
            default: begin
               rx_en   <= line_act;
               rx_data <= line_data;
            end
         endcase
         col_out <= jabber || col_now || sqe_on;
         jab_out <= jabber;
      end
   end
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk #(
   parameter int DATA_W = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic [DATA_W-1:0] tx_data,
   input logic              line_act,
   input logic [DATA_W-1:0] line_data,
   input logic              link_ok,
   input logic              loop_n,
   input logic              fdx_n,
   input logic              jabber,
   input logic              rx_en,
   input logic [DATA_W-1:0] rx_data,
   input logic              col_out,
   input logic              jab_out
);
   logic rst_seen = 1'b0;

   always @(posedge clk) rst_seen <= !rst_n;

   always @(negedge clk) begin
      if (rst_seen) begin
         assert_reset_quiet_R1: assert (!rx_en && rx_data == '0 && !col_out && !jab_out)
            else $error("outputs not cleared by reset");
      end
   end

   assert_loop_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_n && fdx_n && !jabber && tx_en && link_ok) |=> (rx_en && rx_data == $past(tx_data)));

   assert_loop_test_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_n && !tx_en) |=> (!rx_en && rx_data == '0));

   assert_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_n && fdx_n && !jabber && tx_en && line_act) |=> (col_out && !jab_out));

   assert_fdx_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fdx_n && loop_n && !jabber) |=> (rx_en == $past(line_act) && rx_data == $past(line_data)));

   assert_jabber_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      jabber |=> (col_out && jab_out));
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_en    (tx_en),
   .tx_data  (tx_data),
   .line_act (line_act),
   .line_data(line_data),
   .link_ok  (link_ok),
   .loop_n   (loop_n),
   .fdx_n    (fdx_n),
   .jabber   (jabber),
   .rx_en    (rx_en),
   .rx_data  (rx_data),
   .col_out  (col_out),
   .jab_out  (jab_out)
);

// File: tb/xcvr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_tb_top;
   localparam int DLY = 2;
   localparam int WIN = 4;
   localparam int NV  = 12;

   // Row bits: loop_n fdx_n jabber tx_en tx_data line_act line_data link_ok |
   //           exp rx_en, exp rx_data, exp col_out, exp jab_out | requirement number
   localparam logic [15:0] TBL [0:NV-1] = '{
      16'b11011001_1100_0010, // R2 echo of a one
      16'b11010011_1000_0010, // R2 echo of a zero
      16'b11011010_0100_0011, // R3 no link: line routed
      16'b11001111_1100_0011, // R3 idle transmitter: line routed
      16'b11011101_1110_0101, // R5 collision while echoing
      16'b11010110_1110_0101, // R5 collision without link
      16'b01011100_1100_0100, // R4 loop test ignores link
      16'b01001111_0000_0100, // R4 loop test mutes line
      16'b10011101_1000_0110, // R6 full duplex, both sides busy
      16'b10011011_0100_0110, // R6 full duplex, transmit only
      16'b11111101_1011_1001, // R9 jabber routes line
      16'b01111001_0011_1001  // R9 jabber in loop test mutes
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, tx_data = 1'b0, line_act = 1'b0, line_data = 1'b0, link_ok = 1'b0;
   logic loop_n = 1'b1, sqe_en_n = 1'b1, fdx_n = 1'b1, jabber = 1'b0;
   logic rx_en, rx_data, col_out, jab_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xcvr_mode_ctrl #(.DATA_W(1), .SQE_DLY(DLY), .SQE_WIN(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
      .line_act(line_act), .line_data(line_data), .link_ok(link_ok),
      .loop_n(loop_n), .sqe_en_n(sqe_en_n), .fdx_n(fdx_n), .jabber(jabber),
      .rx_en(rx_en), .rx_data(rx_data), .col_out(col_out), .jab_out(jab_out)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // End a frame, then walk the cycles and compare col_out with the expected window
   task automatic sqe_run(input string tag, input bit expect_pulse, input int kill_at);
      tx_en = 1'b1; tx_data = 1'b1;
      step(); step();
      tx_en = 1'b0; line_data = 1'b1;
      step();                               // edge E0 samples the frame end
      for (int k = 1; k <= DLY + WIN + 1; k++) begin
         jabber = (k == kill_at);
         step();
         if (k == kill_at) begin
            check(tag, "col_out during jabber", col_out, 1);
         end else begin
            check(tag, "col_out window", col_out,
                  (expect_pulse && k >= DLY + 1 && k <= DLY + WIN) ? 1 : 0);
            check(tag, "rx_data undisturbed", rx_data, 1);
         end
      end
      jabber = 1'b0; line_data = 1'b0;
      step();
   endtask

   initial begin
      // R1: reset holds every output low even with all inputs active
      tx_en = 1'b1; tx_data = 1'b1; line_act = 1'b1; line_data = 1'b1;
      link_ok = 1'b1; jabber = 1'b1;
      step();
      check("R1", "rx_en", rx_en, 0);
      check("R1", "rx_data", rx_data, 0);
      check("R1", "col_out", col_out, 0);
      check("R1", "jab_out", jab_out, 0);
      tx_en = 1'b0; tx_data = 1'b0; line_act = 1'b0; line_data = 1'b0; jabber = 1'b0;
      step();
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", TBL[i][3:0]);
         {loop_n, fdx_n, jabber, tx_en, tx_data, line_act, line_data, link_ok} = TBL[i][15:8];
         sqe_en_n = 1'b1;
         step();
         check(tag, $sformatf("row %0d rx_en", i), rx_en, TBL[i][7]);
         check(tag, $sformatf("row %0d rx_data", i), rx_data, TBL[i][6]);
         check(tag, $sformatf("row %0d col_out", i), col_out, TBL[i][5]);
         check(tag, $sformatf("row %0d jab_out", i), jab_out, TBL[i][4]);
      end

      loop_n = 1'b1; fdx_n = 1'b1; jabber = 1'b0; tx_en = 1'b0; tx_data = 1'b0;
      line_act = 1'b0; line_data = 1'b0; link_ok = 1'b0;
      step(); step();

      // R7: post-frame pulse in half duplex
      sqe_en_n = 1'b0;
      sqe_run("R7", 1'b1, 0);
      // R10: pulse still produced in full duplex
      fdx_n = 1'b0;
      sqe_run("R10", 1'b1, 0);
      fdx_n = 1'b1;
      // R8: test disabled, no pulse
      sqe_en_n = 1'b1;
      sqe_run("R8", 1'b0, 0);
      // R9: jabber just after the frame end cancels the pending pulse
      sqe_en_n = 1'b0;
      sqe_run("R9", 1'b0, 1);

      // R1: reset taken in the middle of operation clears the outputs again
      tx_en = 1'b1; tx_data = 1'b1; link_ok = 1'b1; jabber = 1'b1;
      step();
      rst_n = 1'b0;
      step();
      check("R1", "rx_en after mid-run reset", rx_en, 0);
      check("R1", "jab_out after mid-run reset", jab_out, 0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule